// File: doc/BRIEF.md
# Converter Result Serial Port with Shared Ready Line

This block is the digital output stage of a single-channel 12-bit sigma-delta converter. An internal sequencer times conversions from the moment the enable input rises: it waits out a power-up delay and a full settling interval, then completes one conversion per fixed period. At each completion the result code and its out-of-range flag, taken from a producer interface, are latched into a frame register. One output line serves as both the data-ready signal and the serial data line. The host sees it go low, then supplies serial clock pulses to shift out a 24-bit frame.

The frame holds the result, MSB first, then four zero bits, then a status byte. In transmission order the status byte carries a ready bit (0 while the frame is valid), a constant zero, the out-of-range flag, a two-bit identity field fixed at 00, and a three-bit check pattern fixed at 101. A host can use the pattern to detect a corrupted transfer. Each result can be read only once. A result that is left unread is withdrawn shortly before the next update: the line goes high for a blanking window, so the host does not start a read that would be cut off. When the enable input is low, the line is released (output enable low).

The serial clock comes from outside and is oversampled in the system clock domain. The host changes it well below the system clock rate.

Top module: `adc_serial_port`

## Requirements
- R1: While `rst` is high or `pwr_en` is low, `sdo_en` is 0 (the line is released) from the next clock edge onward.
- R2: After `pwr_en` is sampled high, the line is driven (`sdo_en`=1) high for exactly PWRUP_CYC+SETTLE_CYC cycles, and then drops low as the first conversion completes.
- R3: When a conversion completes, `sdo` goes low on the following edge and stays low until a serial clock falling edge or the blanking window changes it.
- R4: The frame is FRAME_W=24 bits, sent MSB first: `smp_code[11:0]`, then 4'b0000, then the status byte {ready=0, 0, err, id=2'b00, pattern=3'b101}. Frame bits [7:0] are therefore {2'b00, err, 5'b00101}.
- R5: Each falling edge of `sclk` drives the next frame bit. The bit holds steady until the next falling edge, so the host samples it on the rising edge; `sclk` idles high.
- R6: After the 24th rising `sclk` edge of a frame, `sdo` returns high. Further `sclk` pulses produce no data, and the line stays high until the next conversion completes.
- R7: If a result is not being read, `sdo` goes high BLANK_CYC cycles before the next update. It drops low again when the new result is loaded.
- R8: A conversion that completes during a partial read discards that read. The frame restarts from bit 23 of the new result.
- R9: After the first conversion, conversions complete exactly every PERIOD_CYC cycles.
- R10: The err status bit equals the `smp_err` value sampled when that conversion completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_en | input | 1 | Power enable; low powers down and resets the sequencer |
| sclk | input | 1 | Host serial clock, idle high |
| smp_code | input | RES_W | Conversion result offered by the producer |
| smp_err | input | 1 | Out-of-range flag for that result |
| sdo | output | 1 | Combined ready / serial data line value |
| sdo_en | output | 1 | Output enable of the line (0 = released) |

## Verification
The hardest state to reach is a conversion that completes while a frame is half shifted out. The host never reaches it on its own, because it reads right after the ready edge. The bench records the cycle at which the line went low and shifts out only ten bits. It then holds the serial clock idle and waits until exactly one conversion period has passed, so the next load arrives mid-frame. At that point it checks that the line shows ready and that a full read returns the new result from its first bit. The blanking window and the conversion period are checked the same way: the bench counts cycles from a known load edge rather than waiting on the line.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;
  localparam int STAT_W = 8;
  localparam logic [1:0] DEV_ID   = 2'b00;
  localparam logic [2:0] CHK_PAT  = 3'b101;
  localparam logic       RDY_BIT  = 1'b0;

  function automatic logic [STAT_W-1:0] status_byte(input logic err);
    return {RDY_BIT, 1'b0, err, DEV_ID, CHK_PAT};
  endfunction
endpackage

// File: rtl/adcsp_conv_timer.sv
module adcsp_conv_timer #(
  parameter int FIRST_CYC  = 50,
  parameter int PERIOD_CYC = 200,
  parameter int BLANK_CYC  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_en,
  output logic done,
  output logic blank
);
  localparam int MAXC  = (FIRST_CYC > PERIOD_CYC) ? FIRST_CYC : PERIOD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             run;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      run <= 1'b1;
      cnt <= CNT_W'(FIRST_CYC - 1);
    end else if (cnt == '0) begin
      cnt <= CNT_W'(PERIOD_CYC - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done  = run && (cnt == '0);
  assign blank = run && (cnt != '0) && (cnt <= CNT_W'(BLANK_CYC));
endmodule

// File: rtl/adcsp_frame_shifter.sv
module adcsp_frame_shifter
  import adcsp_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int PAD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic             blank,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  input  logic [RES_W-1:0] code,
  input  logic             err,
  output logic             sdo,
  output logic             sdo_en,
  output logic             busy
);
  localparam int FRAME_W = RES_W + PAD_W + STAT_W;
  localparam int BCNT_W  = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_new;
  logic [BCNT_W-1:0]  bitcnt;
  logic               avail;

  assign frame_new = {code, {PAD_W{1'b0}}, status_byte(err)};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      shreg  <= '0;
      bitcnt <= '0;
      avail  <= 1'b0;
      busy   <= 1'b0;
      sdo    <= 1'b1;
      sdo_en <= 1'b0;
    end else begin
      sdo_en <= 1'b1;
      if (load) begin
        shreg  <= frame_new;
        bitcnt <= '0;
        avail  <= 1'b1;
        busy   <= 1'b0;
        sdo    <= 1'b0;
      end else if (blank && avail && !busy) begin
        avail <= 1'b0;
        sdo   <= 1'b1;
      end else if (avail) begin
        if (sclk_fall) begin
          sdo   <= shreg[FRAME_W-1];
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
          busy  <= 1'b1;
        end else if (sclk_rise && busy) begin
          if (bitcnt == BCNT_W'(FRAME_W - 1)) begin
            avail  <= 1'b0;
            busy   <= 1'b0;
            bitcnt <= '0;
            sdo    <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W      = 12,
  parameter int PAD_W      = 4,
  parameter int PWRUP_CYC  = 100000,
  parameter int SETTLE_CYC = 1600000,
  parameter int PERIOD_CYC = 800000,
  parameter int BLANK_CYC  = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en,
  input  logic             sclk,
  input  logic [RES_W-1:0] smp_code,
  input  logic             smp_err,
  output logic             sdo,
  output logic             sdo_en
);
  localparam int FIRST_CYC = PWRUP_CYC + SETTLE_CYC;

  logic sclk_q;
  logic sclk_fall;
  logic sclk_rise;
  logic conv_done;
  logic conv_blank;
  logic xfer_busy;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk;
  end

  assign sclk_fall = sclk_q && !sclk;
  assign sclk_rise = !sclk_q && sclk;

  adcsp_conv_timer #(
    .FIRST_CYC (FIRST_CYC),
    .PERIOD_CYC(PERIOD_CYC),
    .BLANK_CYC (BLANK_CYC)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .pwr_en(pwr_en),
    .done  (conv_done),
    .blank (conv_blank)
  );

  adcsp_frame_shifter #(
    .RES_W(RES_W),
    .PAD_W(PAD_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en       (pwr_en),
    .load     (conv_done),
    .blank    (conv_blank),
    .sclk_fall(sclk_fall),
    .sclk_rise(sclk_rise),
    .code     (smp_code),
    .err      (smp_err),
    .sdo      (sdo),
    .sdo_en   (sdo_en),
    .busy     (xfer_busy)
  );
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int PERIOD_CYC = 200
) (
  input logic clk,
  input logic rst,
  input logic pwr_en,
  input logic sdo,
  input logic sdo_en,
  input logic conv_done,
  input logic conv_blank,
  input logic sclk_fall,
  input logic sclk_rise,
  input logic xfer_busy
);
  localparam int GAP_W = $clog2(PERIOD_CYC + 1);

  AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> !sdo_en); // R1

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (conv_done && pwr_en) |=> (sdo_en && !sdo)); // R3

  AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (conv_blank && !xfer_busy && pwr_en) |=> sdo); // R7

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && pwr_en && !sclk_fall && !sclk_rise && !conv_done && !conv_blank)
      |=> $stable(sdo)); // R5

  logic [GAP_W-1:0] gap;
  logic             seen;
  always_ff @(posedge clk) begin
    if (rst || !pwr_en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (conv_done) begin
      AST_CONV_PERIOD: assert (!seen || gap == GAP_W'(PERIOD_CYC - 1)); // R9
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != GAP_W'(PERIOD_CYC)) begin
      gap <= gap + 1'b1;
    end
  end
endmodule

bind adc_serial_port adc_serial_port_chk #(.PERIOD_CYC(PERIOD_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_en    (pwr_en),
  .sdo       (sdo),
  .sdo_en    (sdo_en),
  .conv_done (conv_done),
  .conv_blank(conv_blank),
  .sclk_fall (sclk_fall),
  .sclk_rise (sclk_rise),
  .xfer_busy (xfer_busy)
);

// File: tb/adc_serial_port_bench.sv
`timescale 1ns/1ps
module adc_serial_port_bench;
  localparam int RES_W  = 12;
  localparam int PWRUP  = 20;
  localparam int SETTLE = 30;
  localparam int PERIOD = 200;
  localparam int BLANK  = 8;
  localparam int FIRST  = PWRUP + SETTLE;
  localparam int NVEC   = 5;
  // {err, code}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 12'h000}, {1'b1, 12'hFFF}, {1'b0, 12'h800},
    {1'b0, 12'hA5C}, {1'b1, 12'h3C3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_en = 1'b0;
  logic sclk = 1'b1;
  logic [RES_W-1:0] smp_code = '0;
  logic smp_err = 1'b0;
  logic sdo, sdo_en;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_rdy  = 0;

  always #5 clk = ~clk;

  adc_serial_port #(
    .RES_W(RES_W), .PAD_W(4), .PWRUP_CYC(PWRUP), .SETTLE_CYC(SETTLE),
    .PERIOD_CYC(PERIOD), .BLANK_CYC(BLANK)
  ) u_adc_serial_port (
    .clk(clk), .rst(rst), .pwr_en(pwr_en), .sclk(sclk),
    .smp_code(smp_code), .smp_err(smp_err), .sdo(sdo), .sdo_en(sdo_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [23:0] exp_frame(input logic [11:0] c, input logic e);
    return {c, 4'b0000, 2'b00, e, 2'b00, 3'b101};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_bits(input int n, output logic [23:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sclk = 1'b0;
      repeat (2) @(negedge clk);
      got = {got[22:0], sdo};
      sclk = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_fresh();
    int lim;
    lim = 0;
    while (sdo !== 1'b1 && lim < 2000) begin @(negedge clk); lim++; end
    while (sdo !== 1'b0 && lim < 2000) begin @(negedge clk); lim++; end
    t_rdy = cyc;
    check("R3 ready low", {22'b0, sdo_en, sdo}, 24'b10);
  endtask

  initial begin
    logic [23:0] got;
    repeat (3) @(negedge clk);
    check("R1 reset releases line", {23'b0, sdo_en}, 24'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pwr_en low releases line", {23'b0, sdo_en}, 24'd0);

    // R2: power-up timing, R10 data captured at the first load
    smp_code = 12'h5A1; smp_err = 1'b0;
    pwr_en = 1'b1;
    @(posedge clk);
    repeat (FIRST - 1) @(posedge clk);
    @(negedge clk);
    check("R2 held high during power-up", {22'b0, sdo_en, sdo}, 24'b11);
    @(posedge clk); @(negedge clk);
    check("R2 first conversion drops line", {22'b0, sdo_en, sdo}, 24'b10);

    // R7 / R9: unread result blanks, next load exactly one period later
    repeat (PERIOD - BLANK - 1) @(posedge clk);
    @(negedge clk);
    check("R7 still low before blanking", {23'b0, sdo}, 24'd0);
    @(posedge clk); @(negedge clk);
    check("R7 high in blanking window", {23'b0, sdo}, 24'd1);
    repeat (BLANK - 1) @(posedge clk);
    @(negedge clk);
    check("R7 high just before update", {23'b0, sdo}, 24'd1);
    @(posedge clk); @(negedge clk);
    check("R9 reload one period later", {23'b0, sdo}, 24'd0);

    // R4 / R5 / R10 / R6: vector walk
    for (int i = 0; i < NVEC; i++) begin
      smp_code = VEC[i][11:0];
      smp_err  = VEC[i][12];
      wait_fresh();
      read_bits(24, got);
      check("R4 R5 R10 frame contents", got, exp_frame(VEC[i][11:0], VEC[i][12]));
      check("R6 line high after frame", {23'b0, sdo}, 24'd1);
    end

    // R6: extra pulses after the frame give no data
    read_bits(8, got);
    check("R6 no data on extra pulses", got, 24'h0000FF);

    // R8: completion during a partial read
    smp_code = 12'h9C4; smp_err = 1'b0;
    wait_fresh();
    smp_code = 12'h2B7; smp_err = 1'b1;
    read_bits(10, got);
    check("R8 R5 first ten bits of old frame", got, {14'b0, exp_frame(12'h9C4, 1'b0)[23:14]});
    while (cyc < t_rdy + PERIOD) @(negedge clk);
    check("R8 new load shows ready", {23'b0, sdo}, 24'd0);
    read_bits(24, got);
    check("R8 restarted frame is new result", got, exp_frame(12'h2B7, 1'b1));

    // R1: power-down and reset while running
    pwr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 power-down releases line", {23'b0, sdo_en}, 24'd0);
    pwr_en = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 driven high after re-enable", {22'b0, sdo_en, sdo}, 24'b11);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 reset while running", {23'b0, sdo_en}, 24'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule